// File: doc/BRIEF.md
# Configuration Image DMA Command Queue

This block takes DMA commands from software through a small memory-mapped register file and streams the words of a configuration image from memory into a configuration port. Software writes the source address, the destination pair and the source length in 32-bit words. It then writes the destination length, and that write turns the current register contents into one command in a short queue. A fetch engine takes commands from the queue in order. It reads each word through a simple memory read port and hands it to the configuration port over a valid/ready handshake.

Each command raises a per-command done flag when its last word has been accepted. A command whose source address has bit 0 set is the final one of an image. For that command the block also raises a combined done flag, but only once the configuration port reports that it has finished absorbing the data. The register file stays inert until a fixed unlock key is written. Rejected commands raise error flags. Interrupt status bits are cleared by writing ones, and a mask register selects which status bits drive the interrupt line.

Top module: `cfg_dma_cmdq`

## Requirements
- R1: Until 0x757BDF0D is written to offset 0x34, register reads return 0 and all other writes have no effect. Writing any other value to 0x34 leaves the block locked.
- R2: Once unlocked, these registers read back the last value written: control 0x00, lock 0x04, source address 0x18, destination address 0x1C, source length 0x20, destination length 0x24 and misc control 0x80. Status at 0x14 reads bit 31 = queue full and bit 30 = queue empty, with all other bits 0.
- R3: A write to 0x24 that passes all checks pushes one command into a 4-entry queue. The command is built from the source address, source length and destination address last written.
- R4: For each command the engine delivers exactly source-length words in ascending order. It starts at the source address with bit 0 treated as 0 and steps by 4 bytes. The data on the configuration port stays unchanged while valid is high and ready is low.
- R5: Interrupt status bit 13 is set when the last word of a command whose source bit 0 is 0 is accepted. Bit 12 is not set for such a command.
- R6: For a command whose source bit 0 is 1, bits 12 and 13 are set together, and only after the last word is accepted and `cfg_busy` is low.
- R7: If the destination address is not 0xFFFFFFFF or the written destination length is not 0, status bit 11 is set and the command is dropped. This check takes priority over R8, R9 and R10.
- R8: If source address bits [2:1] are not 0, status bit 6 is set and the command is dropped. This check takes priority over R9 and R10.
- R9: A source length of 0 sets status bit 14 and the command is dropped. This check takes priority over R10.
- R10: A push while the queue is full sets status bit 5 and the command is dropped.
- R11: Writing 1 to an interrupt status bit (offset 0x0C) clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over a clear.
- R12: The interrupt mask at 0x10 resets to 0xF8F7F87F and keeps only those bits. A mask bit of 1 suppresses its source, and `irq` is the OR of status AND NOT mask.
- R13: The engine has at most one memory read outstanding. `mem_req` is a one-cycle pulse, and no new request is issued until the data of the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt line |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Memory read byte address |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_data | output | 32 | Configuration word |
| cfg_ready | input | 1 | Configuration port accepts word |
| cfg_busy | input | 1 | Configuration port still processing data |

## Verification
Several properties are checked on every cycle:
- the configuration word stays stable under back-pressure;
- memory requests are single pulses;
- the queue is never full and empty at once;
- the block stays silent while locked;
- every done pulse from the engine shows up in the status register one cycle later.

Other behaviour only the bench scenarios can show: word order and count per command, rejection priority among the error checks, the stall of the combined done flag behind a busy configuration port, queue overflow, and the effect of the mask on the interrupt line.

// File: rtl/cdq_pkg.sv
package cdq_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_LOCK = 8'h04;
  localparam logic [7:0] OFS_ISTS = 8'h0C;
  localparam logic [7:0] OFS_IMSK = 8'h10;
  localparam logic [7:0] OFS_STAT = 8'h14;
  localparam logic [7:0] OFS_SRC  = 8'h18;
  localparam logic [7:0] OFS_DST  = 8'h1C;
  localparam logic [7:0] OFS_SLEN = 8'h20;
  localparam logic [7:0] OFS_DLEN = 8'h24;
  localparam logic [7:0] OFS_KEY  = 8'h34;
  localparam logic [7:0] OFS_MISC = 8'h80;

  localparam logic [31:0] UNLOCK_KEY = 32'h757B_DF0D;
  localparam logic [31:0] IRQ_VALID  = 32'hF8F7_F87F;
  localparam logic [31:0] IRQ_ERRS   = 32'h00F0_C860;

  localparam int BIT_ALL_DONE = 12;
  localparam int BIT_CMD_DONE = 13;
  localparam int BIT_E_OVF    = 5;
  localparam int BIT_E_ALIGN  = 6;
  localparam int BIT_E_DST    = 11;
  localparam int BIT_E_ZLEN   = 14;

  typedef struct packed {
    logic [31:1] waddr;
    logic [31:0] len;
    logic        last;
  } cmd_t;

  typedef enum logic [2:0] {
    E_IDLE  = 3'd0,
    E_REQ   = 3'd1,
    E_WAIT  = 3'd2,
    E_PUSH  = 3'd3,
    E_DRAIN = 3'd4
  } eng_st_t;
endpackage

// File: rtl/cdq_fifo.sv
module cdq_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter type T = logic [7:0]
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  T     din,
  input  logic pop,
  output T     dout,
  output logic full,
  output logic empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  T                 slot_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop, ptr_en;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign ptr_en  = do_push || do_pop;
  assign dout    = slot_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wptr_q] <= din;
  end
endmodule

// File: rtl/cdq_regs.sv
module cdq_regs
  import cdq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  input  logic        q_full,
  input  logic        q_empty,
  output logic        q_push,
  output cmd_t        q_din,
  input  logic        cmd_done,
  input  logic        all_done
);
  logic        unl_q, unl_d;
  logic [31:0] ctrl_q, ctrl_d, lock_q, lock_d, misc_q, misc_d;
  logic [31:0] src_q, src_d, dst_q, dst_d, slen_q, slen_d, dlen_q, dlen_d;
  logic [31:0] sts_q, sts_d, msk_q, msk_d;
  logic        wr_ok, upd_en;

  assign wr_ok  = wr_en && unl_q;
  assign upd_en = wr_en || cmd_done || all_done;
  assign q_din  = cmd_t'{waddr: src_q[31:1], len: slen_q, last: src_q[0]};
  assign irq    = |(sts_q & ~msk_q);

  always_comb begin
    unl_d  = unl_q;
    ctrl_d = ctrl_q;
    lock_d = lock_q;
    misc_d = misc_q;
    src_d  = src_q;
    dst_d  = dst_q;
    slen_d = slen_q;
    dlen_d = dlen_q;
    sts_d  = sts_q;
    msk_d  = msk_q;
    q_push = 1'b0;
    if (wr_en && !unl_q && addr == OFS_KEY && wdata == UNLOCK_KEY) unl_d = 1'b1;
    if (wr_ok) begin
      case (addr)
        OFS_CTRL: ctrl_d = wdata;
        OFS_LOCK: lock_d = wdata;
        OFS_MISC: misc_d = wdata;
        OFS_SRC:  src_d  = wdata;
        OFS_DST:  dst_d  = wdata;
        OFS_SLEN: slen_d = wdata;
        OFS_ISTS: sts_d  = sts_q & ~(wdata & IRQ_VALID);
        OFS_IMSK: msk_d  = wdata & IRQ_VALID;
        OFS_DLEN: begin
          dlen_d = wdata;
          if (dst_q != '1 || wdata != '0) sts_d[BIT_E_DST] = 1'b1;
          else if (src_q[2:1] != 2'b00)   sts_d[BIT_E_ALIGN] = 1'b1;
          else if (slen_q == '0)          sts_d[BIT_E_ZLEN] = 1'b1;
          else if (q_full)                sts_d[BIT_E_OVF] = 1'b1;
          else                            q_push = 1'b1;
        end
        default: ;
      endcase
    end
    if (cmd_done) sts_d[BIT_CMD_DONE] = 1'b1;
    if (all_done) begin
      sts_d[BIT_CMD_DONE] = 1'b1;
      sts_d[BIT_ALL_DONE] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unl_q  <= 1'b0;
      ctrl_q <= '0;
      lock_q <= '0;
      misc_q <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      slen_q <= '0;
      dlen_q <= '0;
      sts_q  <= '0;
      msk_q  <= IRQ_VALID;
    end else if (upd_en) begin
      unl_q  <= unl_d;
      ctrl_q <= ctrl_d;
      lock_q <= lock_d;
      misc_q <= misc_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      slen_q <= slen_d;
      dlen_q <= dlen_d;
      sts_q  <= sts_d;
      msk_q  <= msk_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && unl_q) begin
      case (addr)
        OFS_CTRL: rdata = ctrl_q;
        OFS_LOCK: rdata = lock_q;
        OFS_MISC: rdata = misc_q;
        OFS_SRC:  rdata = src_q;
        OFS_DST:  rdata = dst_q;
        OFS_SLEN: rdata = slen_q;
        OFS_DLEN: rdata = dlen_q;
        OFS_ISTS: rdata = sts_q;
        OFS_IMSK: rdata = msk_q;
        OFS_STAT: rdata = {q_full, q_empty, 30'b0};
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cdq_engine.sv
module cdq_engine
  import cdq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        q_empty,
  input  cmd_t        q_head,
  output logic        q_pop,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        cfg_valid,
  output logic [31:0] cfg_data,
  input  logic        cfg_ready,
  input  logic        cfg_busy,
  output logic        cmd_done,
  output logic        all_done
);
  eng_st_t     st_q, st_d;
  logic [31:0] addr_q, addr_d, rem_q, rem_d, data_q, data_d;
  logic        last_q, last_d;

  assign mem_addr = addr_q;
  assign cfg_data = data_q;

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    rem_d     = rem_q;
    data_d    = data_q;
    last_d    = last_q;
    q_pop     = 1'b0;
    mem_req   = 1'b0;
    cfg_valid = 1'b0;
    cmd_done  = 1'b0;
    all_done  = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (!q_empty) begin
          q_pop  = 1'b1;
          addr_d = {q_head.waddr, 1'b0};
          rem_d  = q_head.len;
          last_d = q_head.last;
          st_d   = E_REQ;
        end
      end
      E_REQ: begin
        mem_req = 1'b1;
        st_d    = E_WAIT;
      end
      E_WAIT: begin
        if (mem_rvalid) begin
          data_d = mem_rdata;
          st_d   = E_PUSH;
        end
      end
      E_PUSH: begin
        cfg_valid = 1'b1;
        if (cfg_ready) begin
          addr_d = addr_q + 32'd4;
          rem_d  = rem_q - 32'd1;
          if (rem_q == 32'd1) begin
            if (last_q) st_d = E_DRAIN;
            else begin
              cmd_done = 1'b1;
              st_d     = E_IDLE;
            end
          end else begin
            st_d = E_REQ;
          end
        end
      end
      E_DRAIN: begin
        if (!cfg_busy) begin
          all_done = 1'b1;
          st_d     = E_IDLE;
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      data_q <= '0;
      last_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == E_IDLE || (st_q == E_PUSH && cfg_ready)) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
        last_q <= last_d;
      end
      if (st_q == E_WAIT && mem_rvalid) data_q <= data_d;
    end
  end
endmodule

// File: rtl/cfg_dma_cmdq.sv
module cfg_dma_cmdq
  import cdq_pkg::*;
#(
  parameter int unsigned Q_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        cfg_valid,
  output logic [31:0] cfg_data,
  input  logic        cfg_ready,
  input  logic        cfg_busy
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       q_push, q_pop, q_full, q_empty, cmd_done, all_done;
  cmd_t       q_din, q_head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cdq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (reg_wr),
    .rd_en    (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .irq      (irq),
    .q_full   (q_full),
    .q_empty  (q_empty),
    .q_push   (q_push),
    .q_din    (q_din),
    .cmd_done (cmd_done),
    .all_done (all_done)
  );

  cdq_fifo #(.DEPTH(Q_DEPTH), .T(cmd_t)) u_queue (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (q_push),
    .din   (q_din),
    .pop   (q_pop),
    .dout  (q_head),
    .full  (q_full),
    .empty (q_empty)
  );

  cdq_engine u_engine (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .q_empty    (q_empty),
    .q_head     (q_head),
    .q_pop      (q_pop),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .cfg_valid  (cfg_valid),
    .cfg_data   (cfg_data),
    .cfg_ready  (cfg_ready),
    .cfg_busy   (cfg_busy),
    .cmd_done   (cmd_done),
    .all_done   (all_done)
  );
endmodule

// File: rtl/cdq_checker.sv
module cdq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        unlocked,
  input logic [31:0] rdata,
  input logic        q_push,
  input logic        q_full,
  input logic        q_empty,
  input logic        mem_req,
  input logic        cfg_valid,
  input logic        cfg_ready,
  input logic [31:0] cfg_data,
  input logic        cmd_done,
  input logic        all_done,
  input logic [31:0] sts
);
  // R1: a locked block neither answers reads nor accepts commands
  a_r1_locked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (rdata == 32'd0 && !q_push));

  // R3: queue never reports full and empty together
  a_r3_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  // R4: held word under back-pressure
  a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

  // R5: per-command done reaches the status register
  a_r5_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> sts[13]);

  // R6: final command sets both done flags
  a_r6_final_sets_both: assert property (@(posedge clk) disable iff (!rst_n)
    all_done |=> (sts[12] && sts[13]));

  // R13: a request is a single-cycle pulse
  a_r13_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
endmodule

bind cfg_dma_cmdq cdq_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .unlocked  (u_regs.unl_q),
  .rdata     (reg_rdata),
  .q_push    (q_push),
  .q_full    (q_full),
  .q_empty   (q_empty),
  .mem_req   (mem_req),
  .cfg_valid (cfg_valid),
  .cfg_ready (cfg_ready),
  .cfg_data  (cfg_data),
  .cmd_done  (cmd_done),
  .all_done  (all_done),
  .sts       (u_regs.sts_q)
);

// File: tb/cfg_dma_cmdq_test.sv
module cfg_dma_cmdq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr, reg_rd, irq, mem_req, mem_rvalid;
  logic        cfg_valid, cfg_ready, cfg_busy;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mem_addr, mem_rdata, cfg_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit ready_hold = 0;
  bit ready_toggle = 0;
  logic [31:0] exp_q [$];

  cfg_dma_cmdq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data),
    .cfg_ready(cfg_ready), .cfg_busy(cfg_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'd3) ^ 32'h1357_9BDF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
    reg_rd = 1'b0;
  endtask

  // driver: writes one command; when accepted its words go to the scoreboard
  task automatic send(input logic [31:0] src, input logic [31:0] dst,
                      input logic [31:0] len, input logic [31:0] dlen, input bit accept);
    wr(8'h18, src);
    wr(8'h1C, dst);
    wr(8'h20, len);
    if (accept)
      for (int i = 0; i < int'(len); i++)
        exp_q.push_back(mem_word({src[31:1], 1'b0} + 32'(4 * i)));
    wr(8'h24, dlen);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    check("R4 all expected words delivered", 32'(exp_q.size()), 32'd0);
  endtask

  // memory responder; also checks R13 (no second request while waiting)
  initial begin
    mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        logic [31:0] a;
        a = mem_addr;
        @(negedge clk);
        check("R13 no request while one is outstanding", {31'b0, mem_req}, 32'd0);
        mem_rvalid = 1'b1;
        mem_rdata  = mem_word(a);
      end
    end
  end

  // configuration-port ready driver
  initial begin
    cfg_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (ready_hold) cfg_ready = 1'b0;
      else if (ready_toggle) cfg_ready = ~cfg_ready;
      else cfg_ready = 1'b1;
    end
  end

  // monitor: pops the scoreboard on every accepted word
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && cfg_valid && cfg_ready) begin
        if (exp_q.size() == 0) check("R4 unexpected word", cfg_data, 32'hFFFF_FFFF);
        else check("R4 word order and value", cfg_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    cfg_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("reset irq", {31'b0, irq}, 32'd0);
    check("reset cfg_valid", {31'b0, cfg_valid}, 32'd0);
    check("reset mem_req", {31'b0, mem_req}, 32'd0);

    // R1 lock behaviour
    rd_check("R1 locked status read", 8'h14, 32'd0);
    wr(8'h18, 32'hDEAD_0000);
    wr(8'h34, 32'h1234_5678);
    rd_check("R1 wrong key keeps lock", 8'h14, 32'd0);
    wr(8'h34, 32'h757B_DF0D);
    rd_check("R1 locked write ignored", 8'h18, 32'd0);
    rd_check("R2 status empty after unlock", 8'h14, 32'h4000_0000);

    // R2 / R12 register read-back
    wr(8'h00, 32'h1234_5678);
    rd_check("R2 control readback", 8'h00, 32'h1234_5678);
    wr(8'h80, 32'h0000_00EF);
    rd_check("R2 misc readback", 8'h80, 32'h0000_00EF);
    wr(8'h04, 32'h0000_0055);
    rd_check("R2 lock readback", 8'h04, 32'h0000_0055);
    rd_check("R12 mask reset value", 8'h10, 32'hF8F7_F87F);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_check("R12 mask keeps valid bits", 8'h10, 32'hF8F7_F87F);

    // R3 R4 R5 plain command with toggling ready
    ready_toggle = 1'b1;
    send(32'h0000_1000, 32'hFFFF_FFFF, 32'd3, 32'd0, 1'b1);
    drain();
    ready_toggle = 1'b0;
    rd_check("R5 per-command done only", 8'h0C, 32'h0000_2000);
    rd_check("R2 dest length readback", 8'h24, 32'd0);
    check("R12 masked source keeps irq low", {31'b0, irq}, 32'd0);

    // R11 write-one-to-clear
    wr(8'h0C, 32'h0000_0000);
    rd_check("R11 zero write leaves bits", 8'h0C, 32'h0000_2000);
    wr(8'h0C, 32'h0000_2000);
    rd_check("R11 one clears bit", 8'h0C, 32'h0000_0000);

    // R12 unmasked interrupt
    wr(8'h10, 32'hF8F7_DFFF);
    send(32'h0000_2008, 32'hFFFF_FFFF, 32'd2, 32'd0, 1'b1);
    drain();
    check("R12 unmasked done raises irq", {31'b0, irq}, 32'd1);
    wr(8'h0C, 32'hFFFF_FFFF);
    #1 check("R12 irq low after clear", {31'b0, irq}, 32'd0);
    wr(8'h10, 32'hFFFF_FFFF);

    // R6 final command waits for the configuration port
    cfg_busy = 1'b1;
    send(32'h0000_5001, 32'hFFFF_FFFF, 32'd2, 32'd0, 1'b1);
    drain();
    rd_check("R6 no done while port busy", 8'h0C, 32'h0000_0000);
    @(negedge clk); cfg_busy = 1'b0;
    repeat (2) @(negedge clk);
    rd_check("R6 both done flags after port idle", 8'h0C, 32'h0000_3000);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R3 R10 queue fill and overflow
    ready_hold = 1'b1;
    for (int k = 0; k < 5; k++)
      send(32'h0000_4000 + 32'(k * 8), 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b1);
    rd_check("R3 queue full after four waiting", 8'h14, 32'h8000_0000);
    send(32'h0000_7000, 32'hFFFF_FFFF, 32'd1, 32'd0, 1'b0);
    rd_check("R10 overflow flag", 8'h0C, 32'h0000_0020);
    wr(8'h0C, 32'hFFFF_FFFF);
    ready_hold = 1'b0;
    drain();
    rd_check("R3 queue empty after drain", 8'h14, 32'h4000_0000);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R8 alignment
    send(32'h0000_3004, 32'hFFFF_FFFF, 32'd2, 32'd0, 1'b0);
    drain();
    rd_check("R8 unaligned source rejected", 8'h0C, 32'h0000_0040);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R9 zero length
    send(32'h0000_3000, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b0);
    drain();
    rd_check("R9 zero length rejected", 8'h0C, 32'h0000_4000);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R7 destination and priority over R8
    send(32'h0000_3000, 32'h0000_0100, 32'd2, 32'd0, 1'b0);
    drain();
    rd_check("R7 memory destination rejected", 8'h0C, 32'h0000_0800);
    wr(8'h0C, 32'hFFFF_FFFF);
    send(32'h0000_3002, 32'hFFFF_FFFF, 32'd2, 32'd4, 1'b0);
    drain();
    rd_check("R7 priority over alignment", 8'h0C, 32'h0000_0800);
    wr(8'h0C, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule